// File: doc/BRIEF.md
# Single-Vector Interrupt Controller with Software Trap

This block gathers the interrupt sources of a small 8-bit processor core and presents them to the core as one request line that always branches to a single fixed vector address. There are three sources:

- an external input pin, detected on an edge that software chooses;
- a timer event pulse, raised on underflow or capture;
- a software trap, raised when the core latches the trap opcode into its instruction register.

The two hardware sources are maskable. Each has its own enable bit, and one global enable bit sits above both. The trap is not maskable. It ranks lowest and is discarded when it meets a hardware request.

Software reaches all control and pending bits through one six-bit register. The core answers a request with a one-cycle acknowledge, and then pushes its PC and jumps to the vector. A hardware acknowledge clears the global enable, so the service routine is not interrupted again. A return-from-interrupt strobe sets the global enable again. A trap acknowledge leaves the global enable as it is, so hardware interrupts can still nest inside trap handling. The source code output tells the core, or a debugger, which source won.

Top module: `irqc_top`

## Requirements
- R1: After reset every control bit is 0 (register reads 0x00, falling edge selected), `irq_req_o` is low and `irq_src_o` is 0.
- R2: Register bit map: bit0 global enable, bit1 external enable, bit2 edge select (1 rising, 0 falling), bit3 external pending, bit4 timer enable, bit5 timer pending. A write with `cfg_we_i` high replaces all six bits at the next clock edge, and the read port shows the register contents directly.
- R3: The external pin passes through two synchronizing flops. An edge that matches the edge select sets the external pending bit at the third clock edge after the pin changes, whatever the enable bits are. An edge of the opposite direction leaves the pending bit unchanged. A pending bit stays set until software writes it to 0, and a detected edge wins over a clearing write made in the same cycle.
- R4: A timer event pulse sampled at a clock edge sets the timer pending bit at that edge, whatever the enable bits are. A timer event wins over a clearing write made in the same cycle.
- R5: A hardware request is raised while global enable is 1 and, for at least one maskable source, both its enable bit and its pending bit are 1. The source code is 1 for external, 2 for timer and 3 for trap. External outranks timer, and both outrank the trap. `irq_vec_o` is always 0x00FF.
- R6: An acknowledge while a hardware request is raised clears the global enable at that edge. The request then drops, so each request gets one acknowledge. Pending bits are not changed by the acknowledge.
- R7: A return-from-interrupt strobe sets the global enable at the next edge. It takes priority over a register write in the same cycle, and a hardware acknowledge in the same cycle takes priority over it.
- R8: An instruction-register strobe carrying opcode 0x00, sampled while no hardware request is raised, starts a trap request at that edge with source code 3, whatever the global enable is. The trap request is held until acknowledged. Its acknowledge clears it and leaves the global enable unchanged.
- R9: A trap opcode that arrives while a hardware request is raised is dropped. A trap request that is waiting when a hardware request is acknowledged is discarded. Neither leaves any record.
- R10: A request is judged from register values held before the current clock edge. A write that clears an enable bit therefore does not withdraw the request in the cycle in which the write is presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronous to clk |
| ext_pin_i | input | 1 | Asynchronous external interrupt pin |
| tmr_evt_i | input | 1 | One-cycle timer underflow or capture pulse |
| ir_valid_i | input | 1 | Strobe: an opcode is being latched into the instruction register |
| ir_opcode_i | input | 8 | Opcode being latched |
| cfg_we_i | input | 1 | Control register write strobe |
| cfg_wdata_i | input | 6 | Control register write data |
| cfg_rdata_o | output | 6 | Control register read data |
| irq_req_o | output | 1 | Interrupt request to the core |
| irq_src_o | output | 2 | Winning source code (0 none, 1 external, 2 timer, 3 trap) |
| irq_vec_o | output | 16 | Fixed branch vector |
| irq_ack_i | input | 1 | One-cycle acknowledge from the core |
| reti_i | input | 1 | Return-from-interrupt strobe |

## Verification
The assertions rely on two assumptions about the core. First, it asserts `irq_ack_i` for one cycle, and only while `irq_req_o` is high. Second, the timer and instruction-register inputs are single-cycle strobes that are already synchronous to `clk`. The random stimulus meets both: it raises acknowledge only in cycles where its own model predicts a request, and it drives every strobe for exactly one cycle. Only the external pin is allowed to change freely, and the two-flop synchronizer absorbs those changes. Directed sequences cover the trap colliding with a hardware request, an enable being cleared while a request is raised, the timing of edge detection, and nesting of a hardware interrupt inside trap service.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  localparam int CTRL_W = 6;
  localparam int SRC_W  = 2;

  // Field order sets the bit map: the last member is bit 0.
  typedef struct packed {
    logic tmr_pend;
    logic tmr_en;
    logic ext_pend;
    logic ext_rise;
    logic ext_en;
    logic gie;
  } ctrl_t;

  typedef enum logic [SRC_W-1:0] {
    SRC_NONE = 2'd0,
    SRC_EXT  = 2'd1,
    SRC_TMR  = 2'd2,
    SRC_TRAP = 2'd3
  } irq_src_e;

endpackage

// File: rtl/irqc_pin_edge.sv
module irqc_pin_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  input  logic rise_sel_i,
  output logic edge_o
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [SYNC_STAGES-1:0] sync_d;
  logic                   last_q;
  logic                   last_d;

  // Input of each stage is the output of the stage before it.
  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        assign sync_d[s] = pin_i;
      end else begin : g_next
        assign sync_d[s] = sync_q[s-1];
      end
    end
  endgenerate

  assign last_d = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      last_q <= last_d;
    end
  end

  always_comb begin
    if (rise_sel_i) edge_o = sync_q[SYNC_STAGES-1] & ~last_q;
    else            edge_o = ~sync_q[SYNC_STAGES-1] & last_q;
  end

endmodule

// File: rtl/irqc_ctrl_regs.sv
module irqc_ctrl_regs
  import irqc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [CTRL_W-1:0] wdata_i,
  input  logic              ext_edge_i,
  input  logic              tmr_evt_i,
  input  logic              ack_hw_i,
  input  logic              reti_i,
  output ctrl_t             ctrl_o
);

  ctrl_t q, d, wr;

  assign wr = ctrl_t'(wdata_i);

  always_comb begin
    d = q;
    if (we_i) d = wr;
    // Event sets win over a clearing write in the same cycle.
    d.ext_pend = (we_i ? wr.ext_pend : q.ext_pend) | ext_edge_i;
    d.tmr_pend = (we_i ? wr.tmr_pend : q.tmr_pend) | tmr_evt_i;
    if (ack_hw_i)    d.gie = 1'b0;
    else if (reti_i) d.gie = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= d;
  end

  assign ctrl_o = q;

  assert_ext_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (q.ext_pend && !we_i) |=> q.ext_pend)
    else $error("external pending dropped without write");

  assert_tmr_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_evt_i |=> q.tmr_pend)
    else $error("timer event not recorded");

  assert_gie_clr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ack_hw_i |=> !q.gie)
    else $error("global enable survived hardware acknowledge");

  assert_gie_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (reti_i && !ack_hw_i) |=> q.gie)
    else $error("return strobe did not set global enable");

endmodule

// File: rtl/irqc_arbiter.sv
module irqc_arbiter
  import irqc_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  ctrl_t    ctrl_i,
  input  logic     trap_i,
  input  logic     ack_i,
  output logic     req_o,
  output irq_src_e src_o,
  output logic     ack_hw_o
);

  logic ext_act, tmr_act, hw_req;
  logic trap_q, trap_d;

  assign ext_act = ctrl_i.gie & ctrl_i.ext_en & ctrl_i.ext_pend;
  assign tmr_act = ctrl_i.gie & ctrl_i.tmr_en & ctrl_i.tmr_pend;
  assign hw_req  = ext_act | tmr_act;

  always_comb begin
    if (ext_act)      src_o = SRC_EXT;
    else if (tmr_act) src_o = SRC_TMR;
    else if (trap_q)  src_o = SRC_TRAP;
    else              src_o = SRC_NONE;
  end

  assign req_o    = hw_req | trap_q;
  assign ack_hw_o = ack_i & hw_req;

  // A trap meeting a hardware request is lost; any acknowledge ends a held trap.
  always_comb begin
    trap_d = (trap_q & ~ack_i) | (trap_i & ~hw_req);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) trap_q <= 1'b0;
    else        trap_q <= trap_d;
  end

  assert_req_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_o && !ctrl_i.gie) |-> (src_o == SRC_TRAP))
    else $error("maskable request without global enable");

  assert_one_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ack_hw_o |=> !(ext_act || tmr_act))
    else $error("hardware request persisted after acknowledge");

  assert_trap_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_i && hw_req && !trap_q) |=> !trap_q)
    else $error("colliding trap was kept");

  assert_trap_take_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_i && !hw_req) |=> trap_q)
    else $error("trap opcode not recorded");

endmodule

// File: rtl/irqc_top.sv
module irqc_top
  import irqc_pkg::*;
#(
  parameter int          OPC_W       = 8,
  parameter int          VEC_W       = 16,
  parameter int          SYNC_STAGES = 2,
  parameter logic [15:0] VECTOR      = 16'h00FF,
  parameter logic [7:0]  TRAP_OPC    = 8'h00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_pin_i,
  input  logic              tmr_evt_i,
  input  logic              ir_valid_i,
  input  logic [OPC_W-1:0]  ir_opcode_i,
  input  logic              cfg_we_i,
  input  logic [CTRL_W-1:0] cfg_wdata_i,
  output logic [CTRL_W-1:0] cfg_rdata_o,
  output logic              irq_req_o,
  output logic [SRC_W-1:0]  irq_src_o,
  output logic [VEC_W-1:0]  irq_vec_o,
  input  logic              irq_ack_i,
  input  logic              reti_i
);

  ctrl_t    ctrl;
  irq_src_e src;
  logic     ext_edge, ack_hw, trap;

  assign trap = ir_valid_i & (ir_opcode_i == TRAP_OPC[OPC_W-1:0]);

  irqc_pin_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk        (clk),
    .rst_n      (rst_n),
    .pin_i      (ext_pin_i),
    .rise_sel_i (ctrl.ext_rise),
    .edge_o     (ext_edge)
  );

  irqc_ctrl_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .we_i       (cfg_we_i),
    .wdata_i    (cfg_wdata_i),
    .ext_edge_i (ext_edge),
    .tmr_evt_i  (tmr_evt_i),
    .ack_hw_i   (ack_hw),
    .reti_i     (reti_i),
    .ctrl_o     (ctrl)
  );

  irqc_arbiter u_arb (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctrl_i   (ctrl),
    .trap_i   (trap),
    .ack_i    (irq_ack_i),
    .req_o    (irq_req_o),
    .src_o    (src),
    .ack_hw_o (ack_hw)
  );

  assign cfg_rdata_o = ctrl;
  assign irq_src_o   = src;
  assign irq_vec_o   = VECTOR[VEC_W-1:0];

  assert_trap_gie_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack_i && src == SRC_TRAP && !reti_i && !cfg_we_i) |=> (ctrl.gie == $past(ctrl.gie)))
    else $error("trap acknowledge altered global enable");

  assert_src_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req_o |-> (src != SRC_NONE))
    else $error("request without a source");

endmodule

// File: tb/irqc_top_test.sv
module irqc_top_test;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       pin, tmr, irv, we, ack, reti;
  logic [7:0] opc;
  logic [5:0] wd;
  logic [5:0] rd;
  logic       req;
  logic [1:0] src;
  logic [15:0] vec;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  // Reference model state
  bit m_gie, m_een, m_erise, m_epend, m_ten, m_tpend, m_trap;
  bit m_s1, m_s2, m_prev;

  always #4 clk = ~clk;

  irqc_top uut (
    .clk(clk), .rst_n(rst_n), .ext_pin_i(pin), .tmr_evt_i(tmr),
    .ir_valid_i(irv), .ir_opcode_i(opc), .cfg_we_i(we), .cfg_wdata_i(wd),
    .cfg_rdata_o(rd), .irq_req_o(req), .irq_src_o(src), .irq_vec_o(vec),
    .irq_ack_i(ack), .reti_i(reti)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit m_hw();
    return m_gie && ((m_een && m_epend) || (m_ten && m_tpend));
  endfunction

  function automatic int m_src();
    if (m_gie && m_een && m_epend) return 1;
    if (m_gie && m_ten && m_tpend) return 2;
    if (m_trap) return 3;
    return 0;
  endfunction

  function automatic int m_reg();
    return {m_tpend, m_ten, m_epend, m_erise, m_een, m_gie};
  endfunction

  task automatic m_update();
    bit hw, edge_hit, trap_in;
    hw       = m_hw();
    edge_hit = m_erise ? (m_s2 && !m_prev) : (!m_s2 && m_prev);
    trap_in  = irv && (opc == 8'h00);
    m_prev = m_s2; m_s2 = m_s1; m_s1 = pin;
    m_trap = (m_trap && !ack) || (trap_in && !hw);
    if (we) begin
      m_een = wd[1]; m_erise = wd[2]; m_ten = wd[4];
      m_epend = wd[3]; m_tpend = wd[5];
    end
    m_epend = m_epend || edge_hit;
    m_tpend = m_tpend || tmr;
    if (ack && hw)  m_gie = 1'b0;
    else if (reti)  m_gie = 1'b1;
    else if (we)    m_gie = wd[0];
  endtask

  task automatic compare();
    int r;
    r = m_reg();
    chk(rd[0] == r[0], "R6 gie", rd[0], r[0]);
    chk(rd[2:1] == r[2:1] && rd[4] == r[4], "R2 fields", rd, r);
    chk(rd[3] == r[3], "R3 ext pending", rd[3], r[3]);
    chk(rd[5] == r[5], "R4 tmr pending", rd[5], r[5]);
    chk(req == (m_hw() || m_trap), "R5 request", req, m_hw() || m_trap);
    chk(src == m_src(), (m_src() == 3) ? "R8 trap source" : "R5 source", src, m_src());
    chk(vec == 16'h00FF, "R5 vector", vec, 16'h00FF);
  endtask

  // One clock: model follows the edge, outputs are compared, strobes drop.
  task automatic cyc();
    @(posedge clk);
    #1;
    m_update();
    compare();
    we = 0; tmr = 0; irv = 0; reti = 0; ack = 0; opc = 8'hA5;
  endtask

  task automatic wr(input logic [5:0] v);
    we = 1; wd = v; cyc();
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "watchdog", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    int seed;
    seed = 20240517;
    void'($urandom(seed));
    pin = 0; tmr = 0; irv = 0; we = 0; ack = 0; reti = 0; opc = 8'hA5; wd = 0;
    rst_n = 0;
    {m_gie, m_een, m_erise, m_epend, m_ten, m_tpend, m_trap, m_s1, m_s2, m_prev} = '0;
    repeat (3) @(posedge clk);
    #2;
    // R1: reset state
    chk(rd == 6'h00, "R1 register", rd, 0);
    chk(req == 1'b0 && src == 2'd0, "R1 request", {req, src}, 0);
    @(negedge clk);
    rst_n = 1;
    cyc();

    // R2: write and read back
    wr(6'h16);
    chk(rd == 6'h16, "R2 readback", rd, 6'h16);

    // R3: rising edge seen at third edge after pin change
    pin = 1; cyc(); cyc();
    chk(rd[3] == 1'b0, "R3 early", rd[3], 0);
    cyc();
    chk(rd[3] == 1'b1, "R3 pending set", rd[3], 1);
    pin = 0; repeat (4) cyc();       // opposite edge: no change
    wr(6'h16);                        // clear pending
    chk(rd[3] == 1'b0, "R3 cleared", rd[3], 0);

    // R10: request holds in the cycle a clearing write is presented
    wr(6'h11);                        // gie + tmr_en
    tmr = 1; cyc();
    chk(req == 1'b1 && src == 2'd2, "R5 timer request", {req, src}, 6);
    we = 1; wd = 6'h30;               // clears gie
    #1;
    chk(req == 1'b1, "R10 old enable used", req, 1);
    cyc();
    chk(req == 1'b0, "R10 after write", req, 0);

    // R9: trap colliding with hardware request is lost
    wr(6'h31);                        // gie, tmr_en, tmr_pend
    irv = 1; opc = 8'h00; cyc();
    chk(src == 2'd2, "R9 hw wins", src, 2);
    ack = 1; cyc();
    chk(req == 1'b0, "R9 trap lost", req, 0);
    chk(rd[0] == 1'b0, "R6 gie cleared", rd[0], 0);
    reti = 1; cyc();
    chk(rd[0] == 1'b1, "R7 reti", rd[0], 1);

    // R8: trap ignores gie and leaves it alone
    wr(6'h00);
    irv = 1; opc = 8'h00; cyc();
    chk(req == 1'b1 && src == 2'd3, "R8 trap no gie", {req, src}, 7);
    ack = 1; cyc();
    chk(req == 1'b0 && rd[0] == 1'b0, "R8 ack", {req, rd[0]}, 0);
    wr(6'h01);
    irv = 1; opc = 8'h00; cyc();
    ack = 1; cyc();
    chk(rd[0] == 1'b1, "R8 gie kept", rd[0], 1);

    // R4: timer event beats clearing write
    wr(6'h20);
    we = 1; wd = 6'h00; tmr = 1; cyc();
    chk(rd[5] == 1'b1, "R4 event wins", rd[5], 1);

    // Random phase
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 9) == 0) pin = ~pin;
      tmr  = ($urandom_range(0, 9) == 0);
      irv  = ($urandom_range(0, 6) == 0);
      opc  = $urandom_range(0, 1) ? 8'h00 : 8'($urandom_range(1, 255));
      we   = ($urandom_range(0, 11) == 0);
      wd   = 6'($urandom);
      reti = ($urandom_range(0, 19) == 0);
      ack  = (m_hw() || m_trap) && ($urandom_range(0, 1) == 1);
      cyc();
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule